// File: doc/BRIEF.md
# Calibration Step Sequencer

This block is the controlling state machine of a memory-interface calibration flow. After a start pulse it walks through a fixed chain of calibration stages, then hands the interface over to normal operation. The stages are: training-pattern loading, read capture-clock phase calibration, read/write latency calibration, an optional one-cycle address/command delay, postamble cycle selection, and user-mode preparation. User-mode preparation programs the mode registers and then leaves voltage/temperature tracking running.

Pattern loading is carried out by the block itself. It issues simple write and read requests on a command port to a reserved region: bank 0, row 0, columns 0 to CAL_COLS-1. Because write latency is still unknown at that point, the load is done in two rounds. Each round is a write pass and then a read pass, followed by a single-pin capture-phase sweep. Every other stage runs in an external engine. The sequencer starts that engine over a shared start/done handshake that carries a step code.

If the address/command delay is requested when the latency stage finishes, the sequencer applies the delay and runs pattern loading, phase calibration and latency calibration again under the new setting. It then continues to the postamble stage. A failure reported by any stage stops the run and leaves the failing step code visible.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, busy, cal_done, cal_ready, cal_fail, cmd_valid and sub_start are 0, and active_step and fail_step are 0.
- R2: With the delay request low, the handshakes carry step codes in the order 2, 2, 3, 4, 6, 7. The codes are: 2 single-pin sweep, 3 capture-phase, 4 latency, 5 address/command delay, 6 postamble, 7 user mode. sub_start is a one-cycle pulse.
- R3: Each pattern round issues CAL_COLS writes (cmd_we=1) to columns 0 to CAL_COLS-1 in ascending order, then CAL_COLS reads (cmd_we=0) of the same columns. All requests use bank 0 and row 0. A full run without the delay has two rounds (224 accepted requests at the default).
- R4: Write data is the nibble 4'b0011 repeated across cmd_wdata (16'h3333 at the default width), so both double-data-rate bit pairs toggle.
- R5: While cmd_valid is high and cmd_ready is low, the request is held: cmd_valid stays high and cmd_col and cmd_we do not change.
- R6: cfg_addcmd_dly is sampled when the latency stage completes. If it is high, a handshake with code 5 follows. addcmd_on rises after that handshake completes. The sequence 2, 2, 3, 4 then runs again, followed by 6 and 7, with no second delay handshake (448 requests).
- R7: A stage that completes with sub_fail high ends the run. cal_fail goes to 1 and fail_step holds that stage's code. busy drops, and no further handshake or command is issued.
- R8: cal_done is a single-cycle pulse raised only after the user-mode stage completes. cal_ready is set together with it and stays high until the next accepted start.
- R9: busy is high from the cycle after an accepted start until the run ends. busy is never high together with cal_ready or cal_fail.
- R10: A start pulse during a run, and a sub_done pulse while no handshake is pending, have no effect on the sequence.
- R11: A start after a failed or completed run clears cal_fail, fail_step and addcmd_on and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (accepted only when no run is active) |
| cfg_addcmd_dly | input | 1 | Request the extra address/command cycle |
| sub_start | output | 1 | One-cycle launch pulse for an external stage |
| sub_step | output | 3 | Step code of the stage being launched or awaited |
| sub_done | input | 1 | Stage completion pulse |
| sub_fail | input | 1 | Stage failed, valid with sub_done |
| cmd_valid | output | 1 | Calibration request valid |
| cmd_ready | input | 1 | Request accepted when high with cmd_valid |
| cmd_we | output | 1 | 1 write, 0 read |
| cmd_bank | output | BANK_W | Bank address |
| cmd_row | output | ROW_W | Row address |
| cmd_col | output | COL_W | Column address |
| cmd_wdata | output | DATA_W | Write data |
| active_step | output | 3 | Code of the running stage (1 pattern load, 0 none) |
| addcmd_on | output | 1 | Extra address/command cycle applied |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Run completed successfully (pulse) |
| cal_ready | output | 1 | Calibrated, normal operation with tracking |
| cal_fail | output | 1 | Run aborted by a failed stage |
| fail_step | output | 3 | Step code of the failing stage |

## Verification
The assertions assume that sub_done arrives only after a sub_start and never in the same cycle as it. They also assume that sub_fail is meaningful only together with sub_done, and that cmd_ready may be withdrawn at any time. The stimulus follows these rules: its stage responder answers each launch a fixed three cycles later with a single done pulse. Its ready pattern either holds cmd_ready high or drops it every third cycle. The one deliberately stray done pulse is placed inside a pattern-load pass, where no handshake is awaited.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [2:0] {
      STEP_NONE      = 3'd0,
      STEP_PATTERN   = 3'd1,
      STEP_PINSWEEP  = 3'd2,
      STEP_PHASE     = 3'd3,
      STEP_LATENCY   = 3'd4,
      STEP_ADDCMD    = 3'd5,
      STEP_POSTAMBLE = 3'd6,
      STEP_USERMODE  = 3'd7
   } cal_step_e;

   localparam int unsigned STEP_W = 3;

   localparam logic [3:0] MIXED_NIBBLE = 4'b0011;

endpackage

// File: rtl/cal_pattern_engine.sv
module cal_pattern_engine
   import cal_seq_pkg::*;
#(
   parameter int unsigned CAL_COLS = 56,
   parameter int unsigned COL_W    = 10,
   parameter int unsigned DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              cmd_ready,
   output logic              cmd_valid,
   output logic              cmd_we,
   output logic [COL_W-1:0]  cmd_col,
   output logic [DATA_W-1:0] cmd_wdata,
   output logic              round_fin
);

   localparam int unsigned CNT_W  = (CAL_COLS > 1) ? $clog2(CAL_COLS) : 1;
   localparam int unsigned N_NIB  = DATA_W / 4;
   localparam logic [CNT_W-1:0] LAST_COL = CNT_W'(CAL_COLS - 1);

   typedef enum logic [1:0] {
      PE_IDLE  = 2'd0,
      PE_WRITE = 2'd1,
      PE_READ  = 2'd2
   } pe_state_e;

   pe_state_e        pe_q;
   logic [CNT_W-1:0] col_q;
   logic             accept;
   logic             at_last;

   assign cmd_valid = (pe_q != PE_IDLE);
   assign cmd_we    = (pe_q == PE_WRITE);
   assign accept    = cmd_valid && cmd_ready;
   assign at_last   = (col_q == LAST_COL);
   assign round_fin = accept && at_last && (pe_q == PE_READ);
   assign cmd_col   = COL_W'(col_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pe_q  <= PE_IDLE;
         col_q <= '0;
      end else if (pe_q == PE_IDLE) begin
         if (go) begin
            pe_q  <= PE_WRITE;
            col_q <= '0;
         end
      end else if (accept) begin
         if (at_last) begin
            col_q <= '0;
            pe_q  <= (pe_q == PE_WRITE) ? PE_READ : PE_IDLE;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N_NIB; g++) begin : g_nibble
      assign cmd_wdata[g*4 +: 4] = cmd_we ? MIXED_NIBBLE : 4'b0000;
   end

endmodule

// File: rtl/cal_step_fsm.sv
module cal_step_fsm
   import cal_seq_pkg::*;
#(
   parameter int unsigned ROUNDS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_addcmd_dly,
   input  logic              sub_done,
   input  logic              sub_fail,
   input  logic              pat_fin,
   output logic              pat_go,
   output logic              sub_start,
   output logic [STEP_W-1:0] sub_step,
   output logic [STEP_W-1:0] active_step,
   output logic              addcmd_on,
   output logic              ev_begin,
   output logic              ev_pass,
   output logic              ev_abort
);

   localparam int unsigned RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

   cal_step_e        st_q, st_d;
   logic [RND_W-1:0] rnd_q;
   logic             hs_wait, hs_ok, hs_bad;
   logic             launch, go_pat, next_rnd, set_dly;

   assign hs_wait  = (st_q != STEP_NONE) && (st_q != STEP_PATTERN);
   assign hs_ok    = hs_wait && sub_done && !sub_fail;
   assign hs_bad   = hs_wait && sub_done && sub_fail;
   assign ev_begin = (st_q == STEP_NONE) && start;
   assign ev_pass  = (st_q == STEP_USERMODE) && hs_ok;
   assign ev_abort = hs_bad;

   always_comb begin
      st_d     = st_q;
      launch   = 1'b0;
      go_pat   = 1'b0;
      next_rnd = 1'b0;
      set_dly  = 1'b0;
      unique case (st_q)
         STEP_NONE: begin
            if (start) begin
               st_d   = STEP_PATTERN;
               go_pat = 1'b1;
            end
         end
         STEP_PATTERN: begin
            if (pat_fin) begin
               st_d   = STEP_PINSWEEP;
               launch = 1'b1;
            end
         end
         STEP_PINSWEEP: begin
            if (hs_ok) begin
               if (rnd_q == LAST_RND) begin
                  st_d   = STEP_PHASE;
                  launch = 1'b1;
               end else begin
                  st_d     = STEP_PATTERN;
                  go_pat   = 1'b1;
                  next_rnd = 1'b1;
               end
            end
         end
         STEP_PHASE: begin
            if (hs_ok) begin
               st_d   = STEP_LATENCY;
               launch = 1'b1;
            end
         end
         STEP_LATENCY: begin
            if (hs_ok) begin
               st_d   = (cfg_addcmd_dly && !addcmd_on) ? STEP_ADDCMD : STEP_POSTAMBLE;
               launch = 1'b1;
            end
         end
         STEP_ADDCMD: begin
            if (hs_ok) begin
               st_d    = STEP_PATTERN;
               go_pat  = 1'b1;
               set_dly = 1'b1;
            end
         end
         STEP_POSTAMBLE: begin
            if (hs_ok) begin
               st_d   = STEP_USERMODE;
               launch = 1'b1;
            end
         end
         STEP_USERMODE: begin
            if (hs_ok) st_d = STEP_NONE;
         end
         default: st_d = STEP_NONE;
      endcase
      if (hs_bad) begin
         st_d   = STEP_NONE;
         launch = 1'b0;
         go_pat = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= STEP_NONE;
         rnd_q     <= '0;
         sub_start <= 1'b0;
         sub_step  <= STEP_NONE;
         pat_go    <= 1'b0;
         addcmd_on <= 1'b0;
      end else begin
         st_q      <= st_d;
         sub_start <= launch;
         pat_go    <= go_pat;
         if (launch)
            sub_step <= st_d;
         else if (hs_wait && sub_done)
            sub_step <= STEP_NONE;
         if (next_rnd)
            rnd_q <= rnd_q + 1'b1;
         else if (go_pat)
            rnd_q <= '0;
         if (ev_begin)
            addcmd_on <= 1'b0;
         else if (set_dly)
            addcmd_on <= 1'b1;
      end
   end

   assign active_step = st_q;

endmodule

// File: rtl/cal_status.sv
module cal_status
   import cal_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_begin,
   input  logic              ev_pass,
   input  logic              ev_abort,
   input  logic [STEP_W-1:0] abort_step,
   output logic              busy,
   output logic              cal_done,
   output logic              cal_ready,
   output logic              cal_fail,
   output logic [STEP_W-1:0] fail_step
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cal_done  <= 1'b0;
         cal_ready <= 1'b0;
         cal_fail  <= 1'b0;
         fail_step <= '0;
      end else begin
         cal_done <= ev_pass;
         if (ev_begin) begin
            busy      <= 1'b1;
            cal_ready <= 1'b0;
            cal_fail  <= 1'b0;
            fail_step <= '0;
         end else if (ev_pass) begin
            busy      <= 1'b0;
            cal_ready <= 1'b1;
         end else if (ev_abort) begin
            busy      <= 1'b0;
            cal_fail  <= 1'b1;
            fail_step <= abort_step;
         end
      end
   end

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
   import cal_seq_pkg::*;
#(
   parameter int unsigned CAL_COLS = 56,
   parameter int unsigned ROUNDS   = 2,
   parameter int unsigned BANK_W   = 3,
   parameter int unsigned ROW_W    = 13,
   parameter int unsigned COL_W    = 10,
   parameter int unsigned DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_addcmd_dly,
   output logic              sub_start,
   output logic [2:0]        sub_step,
   input  logic              sub_done,
   input  logic              sub_fail,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic              cmd_we,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic [DATA_W-1:0] cmd_wdata,
   output logic [2:0]        active_step,
   output logic              addcmd_on,
   output logic              busy,
   output logic              cal_done,
   output logic              cal_ready,
   output logic              cal_fail,
   output logic [2:0]        fail_step
);

   if (DATA_W % 4 != 0 || DATA_W == 0) begin : g_bad_data_w
      $error("cal_seq_top: DATA_W must be a non-zero multiple of 4");
   end
   if (CAL_COLS < 1 || CAL_COLS > (1 << COL_W)) begin : g_bad_cols
      $error("cal_seq_top: CAL_COLS must fit the column address");
   end
   if (ROUNDS < 1) begin : g_bad_rounds
      $error("cal_seq_top: ROUNDS must be at least 1");
   end

   logic pat_go, pat_fin;
   logic ev_begin, ev_pass, ev_abort;

   assign cmd_bank = '0;
   assign cmd_row  = '0;

   cal_step_fsm #(
      .ROUNDS (ROUNDS)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (start),
      .cfg_addcmd_dly (cfg_addcmd_dly),
      .sub_done       (sub_done),
      .sub_fail       (sub_fail),
      .pat_fin        (pat_fin),
      .pat_go         (pat_go),
      .sub_start      (sub_start),
      .sub_step       (sub_step),
      .active_step    (active_step),
      .addcmd_on      (addcmd_on),
      .ev_begin       (ev_begin),
      .ev_pass        (ev_pass),
      .ev_abort       (ev_abort)
   );

   cal_pattern_engine #(
      .CAL_COLS (CAL_COLS),
      .COL_W    (COL_W),
      .DATA_W   (DATA_W)
   ) u_pattern (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (pat_go),
      .cmd_ready (cmd_ready),
      .cmd_valid (cmd_valid),
      .cmd_we    (cmd_we),
      .cmd_col   (cmd_col),
      .cmd_wdata (cmd_wdata),
      .round_fin (pat_fin)
   );

   cal_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_begin   (ev_begin),
      .ev_pass    (ev_pass),
      .ev_abort   (ev_abort),
      .abort_step (active_step),
      .busy       (busy),
      .cal_done   (cal_done),
      .cal_ready  (cal_ready),
      .cal_fail   (cal_fail),
      .fail_step  (fail_step)
   );

endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker #(
   parameter int unsigned CAL_COLS = 56,
   parameter int unsigned COL_W    = 10,
   parameter int unsigned DATA_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sub_start,
   input logic [2:0]        sub_step,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              cmd_we,
   input logic [COL_W-1:0]  cmd_col,
   input logic [DATA_W-1:0] cmd_wdata,
   input logic              addcmd_on,
   input logic              busy,
   input logic              cal_done,
   input logic              cal_ready,
   input logic              cal_fail
);

   assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_col) && $stable(cmd_we));

   assert_col_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (int'(cmd_col) < CAL_COLS));

   assert_mixed_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_we |-> cmd_wdata[3:0] == 4'b0011);

   assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sub_start |=> !sub_start);

   assert_launch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sub_start |-> sub_step >= 3'd2);

   assert_done_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> cal_ready);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done);

   assert_busy_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cal_ready && !cal_fail);

   assert_fail_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_fail |-> !cmd_valid && !sub_start);

   assert_delay_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addcmd_on) |-> busy);

endmodule

bind cal_seq_top cal_seq_checker #(
   .CAL_COLS (CAL_COLS),
   .COL_W    (COL_W),
   .DATA_W   (DATA_W)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .sub_start (sub_start),
   .sub_step  (sub_step),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_we    (cmd_we),
   .cmd_col   (cmd_col),
   .cmd_wdata (cmd_wdata),
   .addcmd_on (addcmd_on),
   .busy      (busy),
   .cal_done  (cal_done),
   .cal_ready (cal_ready),
   .cal_fail  (cal_fail)
);

// File: tb/cal_seq_top_bench.sv
module cal_seq_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CAL_COLS   = 56;
   localparam int BANK_W     = 3;
   localparam int ROW_W      = 13;
   localparam int COL_W      = 10;
   localparam int DATA_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start;
   logic              cfg_addcmd_dly;
   logic              sub_start;
   logic [2:0]        sub_step;
   logic              sub_done;
   logic              sub_fail;
   logic              cmd_valid;
   logic              cmd_ready;
   logic              cmd_we;
   logic [BANK_W-1:0] cmd_bank;
   logic [ROW_W-1:0]  cmd_row;
   logic [COL_W-1:0]  cmd_col;
   logic [DATA_W-1:0] cmd_wdata;
   logic [2:0]        active_step;
   logic              addcmd_on;
   logic              busy;
   logic              cal_done;
   logic              cal_ready;
   logic              cal_fail;
   logic [2:0]        fail_step;

   cal_seq_top #(
      .CAL_COLS (CAL_COLS),
      .BANK_W   (BANK_W),
      .ROW_W    (ROW_W),
      .COL_W    (COL_W),
      .DATA_W   (DATA_W)
   ) u_cal_seq_top (.*);

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;

   // written only by the scenario tasks
   int run_id   = 0;
   int stray_id = 0;
   int fail_at  = -1;
   bit bp_mode  = 1'b0;

   // written only by the monitor/responder
   int         seen_run   = 0;
   int         seen_stray = 0;
   int         cmd_n      = 0;
   int         cmd_err    = 0;
   int         stall_err  = 0;
   int         hs_n       = 0;
   int         hs_log [0:31];
   int         done_cyc   = 0;
   int         cd         = 0;
   int         cyc        = 0;
   bit         dly_at_req = 1'b1;
   bit         prev_stall = 1'b0;
   logic [COL_W-1:0] prev_col = '0;
   logic       prev_we    = 1'b0;

   initial begin
      cmd_ready = 1'b1;
      sub_done  = 1'b0;
      sub_fail  = 1'b0;
   end

   always @(negedge clk) begin
      cyc++;
      if (run_id != seen_run) begin
         seen_run   = run_id;
         cmd_n      = 0;
         cmd_err    = 0;
         stall_err  = 0;
         hs_n       = 0;
         done_cyc   = 0;
         dly_at_req = 1'b1;
      end
      cmd_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
      sub_done  = 1'b0;
      sub_fail  = 1'b0;
      if (cd > 0) begin
         cd--;
         if (cd == 0) begin
            sub_done = 1'b1;
            sub_fail = (hs_n - 1 == fail_at);
         end
      end
      if (stray_id != seen_stray) begin
         seen_stray = stray_id;
         sub_done   = 1'b1;
      end
      if (sub_start) begin
         if (hs_n < 32) hs_log[hs_n] = int'(sub_step);
         if (sub_step == 3'd5) dly_at_req = addcmd_on;
         hs_n++;
         cd = 3;
      end
      #1;
      if (cal_done) done_cyc++;
      if (prev_stall && (!cmd_valid || cmd_col != prev_col || cmd_we != prev_we))
         stall_err++;
      prev_stall = cmd_valid && !cmd_ready;
      prev_col   = cmd_col;
      prev_we    = cmd_we;
      if (cmd_valid && cmd_ready) begin
         int p;
         p = cmd_n % (2 * CAL_COLS);
         if (cmd_we != (p < CAL_COLS) || int'(cmd_col) != (p % CAL_COLS) ||
             cmd_bank != '0 || cmd_row != '0 ||
             (cmd_we && cmd_wdata != 16'h3333))
            cmd_err++;
         cmd_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_hs(input int e[$], input string req);
      int mism;
      mism = 0;
      for (int i = 0; i < e.size() && i < 32; i++)
         if (i >= hs_n || hs_log[i] != e[i]) mism++;
      chk(hs_n == e.size(), req, "handshake count", hs_n, e.size());
      chk(mism == 0, req, "handshake order mismatches", mism, 0);
   endtask

   bit busy_after_start;

   task automatic run_cal(input bit dly, input bit bp, input int fa, input int inj);
      int guard;
      fail_at        = fa;
      bp_mode        = bp;
      cfg_addcmd_dly = dly;
      run_id++;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      busy_after_start = busy;
      guard = 0;
      while (!(cal_ready || cal_fail) && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (guard == inj) begin
            start = 1'b1;
            stray_id++;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(busy == 0,        "R1", "busy", busy, 0);
      chk(cal_done == 0,    "R1", "cal_done", cal_done, 0);
      chk(cal_ready == 0,   "R1", "cal_ready", cal_ready, 0);
      chk(cal_fail == 0,    "R1", "cal_fail", cal_fail, 0);
      chk(cmd_valid == 0,   "R1", "cmd_valid", cmd_valid, 0);
      chk(sub_start == 0,   "R1", "sub_start", sub_start, 0);
      chk(active_step == 0, "R1", "active_step", active_step, 0);
      chk(fail_step == 0,   "R1", "fail_step", fail_step, 0);
   endtask

   task automatic t_nominal();
      int e[$];
      e = '{2, 2, 3, 4, 6, 7};
      run_cal(1'b0, 1'b0, -1, -1);
      chk(busy_after_start == 1, "R9", "busy after start", busy_after_start, 1);
      chk_hs(e, "R2");
      chk(cmd_n == 2 * 2 * CAL_COLS, "R3", "accepted requests", cmd_n, 2 * 2 * CAL_COLS);
      chk(cmd_err == 0, "R3", "request order/address errors", cmd_err, 0);
      chk(cmd_err == 0, "R4", "write data errors", cmd_err, 0);
      chk(done_cyc == 1, "R8", "cal_done cycles", done_cyc, 1);
      chk(cal_ready == 1, "R8", "cal_ready", cal_ready, 1);
      chk(cal_fail == 0, "R8", "cal_fail", cal_fail, 0);
      chk(busy == 0, "R9", "busy after end", busy, 0);
      chk(addcmd_on == 0, "R6", "addcmd_on without request", addcmd_on, 0);
      repeat (20) @(negedge clk);
      chk(cal_ready == 1, "R8", "cal_ready held", cal_ready, 1);
      chk(done_cyc == 1, "R8", "no further done", done_cyc, 1);
   endtask

   task automatic t_backpressure();
      run_cal(1'b0, 1'b1, -1, -1);
      chk(stall_err == 0, "R5", "held-request violations", stall_err, 0);
      chk(cmd_n == 2 * 2 * CAL_COLS, "R5", "accepted requests", cmd_n, 2 * 2 * CAL_COLS);
      chk(cmd_err == 0, "R3", "request order under backpressure", cmd_err, 0);
      chk(cal_ready == 1, "R5", "cal_ready", cal_ready, 1);
   endtask

   task automatic t_addcmd();
      int e[$];
      e = '{2, 2, 3, 4, 5, 2, 2, 3, 4, 6, 7};
      run_cal(1'b1, 1'b0, -1, -1);
      chk_hs(e, "R6");
      chk(cmd_n == 4 * 2 * CAL_COLS, "R6", "accepted requests", cmd_n, 4 * 2 * CAL_COLS);
      chk(cmd_err == 0, "R6", "request errors", cmd_err, 0);
      chk(dly_at_req == 0, "R6", "addcmd_on at delay launch", dly_at_req, 0);
      chk(addcmd_on == 1, "R6", "addcmd_on at end", addcmd_on, 1);
      chk(cal_ready == 1, "R6", "cal_ready", cal_ready, 1);
   endtask

   task automatic t_fail_latency();
      run_cal(1'b0, 1'b0, 3, -1);
      chk(cal_fail == 1, "R7", "cal_fail", cal_fail, 1);
      chk(fail_step == 4, "R7", "fail_step", fail_step, 4);
      chk(cal_ready == 0, "R7", "cal_ready", cal_ready, 0);
      chk(busy == 0, "R7", "busy", busy, 0);
      chk(done_cyc == 0, "R7", "cal_done cycles", done_cyc, 0);
      chk(cmd_n == 2 * 2 * CAL_COLS, "R7", "accepted requests", cmd_n, 2 * 2 * CAL_COLS);
      repeat (30) @(negedge clk);
      chk(hs_n == 4, "R7", "handshakes after failure", hs_n, 4);
      chk(active_step == 0, "R7", "active_step", active_step, 0);
   endtask

   task automatic t_fail_sweep();
      run_cal(1'b0, 1'b0, 0, -1);
      chk(fail_step == 2, "R7", "fail_step in sweep", fail_step, 2);
      chk(cmd_n == 2 * CAL_COLS, "R7", "requests before sweep failure", cmd_n, 2 * CAL_COLS);
      chk(hs_n == 1, "R7", "handshakes", hs_n, 1);
   endtask

   task automatic t_restart();
      int e[$];
      e = '{2, 2, 3, 4, 6, 7};
      run_cal(1'b0, 1'b0, -1, -1);
      chk(cal_fail == 0, "R11", "cal_fail cleared", cal_fail, 0);
      chk(fail_step == 0, "R11", "fail_step cleared", fail_step, 0);
      chk(cal_ready == 1, "R11", "cal_ready", cal_ready, 1);
      chk_hs(e, "R11");
   endtask

   task automatic t_restart_after_delay();
      run_cal(1'b0, 1'b0, -1, -1);
      chk(addcmd_on == 0, "R11", "addcmd_on cleared on restart", addcmd_on, 0);
   endtask

   task automatic t_ignored();
      int e[$];
      e = '{2, 2, 3, 4, 6, 7};
      run_cal(1'b0, 1'b0, -1, 50);
      chk_hs(e, "R10");
      chk(cmd_n == 2 * 2 * CAL_COLS, "R10", "accepted requests", cmd_n, 2 * 2 * CAL_COLS);
      chk(cmd_err == 0, "R10", "request errors", cmd_err, 0);
      chk(done_cyc == 1, "R10", "cal_done cycles", done_cyc, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n          = 1'b0;
      start          = 1'b0;
      cfg_addcmd_dly = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_nominal();
      t_backpressure();
      t_addcmd();
      t_restart_after_delay();
      t_fail_latency();
      t_restart();
      t_fail_sweep();
      t_ignored();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule